// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers 32-bit processor addresses toward one of several target ports through five windows that software sets up. Each window is described by four 32-bit registers: a control word that holds an enable and a 4-bit target code, a size mask, a base page and a remap page. Software reaches these registers through a simple word-wide read/write bus. Reads are combinational. A write takes effect at the next clock edge.

Windows sit on 64 KiB pages. The size register is a run of ones starting at the least significant bit. Each one bit widens the window by a power of two, so a window's byte size is (size + 1) × 64 KiB. A lookup compares only the page bits that the size mask leaves uncovered. When more than one window claims the address, the lowest-numbered window wins.

The outputs are registered one cycle after an address is presented. They give hit or miss, the winning window, its target code and a translated address. The translated address keeps the in-window bits and takes the upper bits from the remap page. Target code 0 is used for main memory and code 2 for the peripheral expansion bus, but the decoder passes any code through unchanged.

Top module: `addr_win_decoder`

## Requirements
- R1: There are five windows. Window n occupies bytes n×0x10 to n×0x10+0xF of the register space. Within a window slot, offset 0x0 is control, 0x4 is size, 0x8 is base and 0xC is remap. A read of any of these 20 words returns the full 32-bit value last written.
- R2: Asynchronous active-low reset clears every register and every decode output to zero, so all windows start disabled.
- R3: An access whose byte offset has bits [1:0] not equal to zero, or whose offset is 0x50 or above, reads as zero and changes no register.
- R4: Control bit 0 enables a window. A window with this bit clear never hits, whatever its size and base.
- R5: An enabled window w hits address A when (A[31:16] & ~size[15:0]) == (base[15:0] & ~size[15:0]).
- R6: When several windows hit, the reported window number is the lowest one that hits.
- R7: When no window hits a valid lookup, out_miss is 1, out_hit is 0, out_win is 0, out_tgt is 4'hF and out_addr equals the input address.
- R8: On a hit, out_tgt equals control bits [7:4] of the winning window.
- R9: On a hit, out_addr[15:0] equals the input address bits [15:0]. Each bit of out_addr[31:16] comes from the input address where size[15:0] is one and from remap[15:0] where size is zero. When remap equals base, the address passes through unchanged.
- R10: A lookup presented with dec_valid in one cycle appears on the outputs after the next rising clock edge, with out_valid set. The lookup uses the register contents from before any write in that same cycle. Without dec_valid, out_valid, out_hit and out_miss are 0 and out_win, out_tgt and out_addr hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| dec_valid | input | 1 | Lookup request |
| dec_addr | input | 32 | Address to decode |
| out_valid | output | 1 | Lookup result present |
| out_hit | output | 1 | A window matched |
| out_miss | output | 1 | No window matched |
| out_win | output | 3 | Winning window number |
| out_tgt | output | 4 | Target code (4'hF on miss) |
| out_addr | output | 32 | Translated address |

## Verification
The assertions check several properties on every cycle:
- hit and miss are never both set;
- a miss always reports target 4'hF;
- the granted window vector is at most one-hot;
- on a hit, the low 16 address bits are carried through;
- out_valid follows dec_valid exactly one cycle later;
- writes to unmapped offsets leave every window setting unchanged.

Only the bench's scenarios can show the behaviours that depend on stored settings:
- mask-based matching;
- the lowest window winning an overlap;
- a disabled window that would otherwise cover every address;
- remapped upper bits;
- read-back of the full words.

The bench checks these against a behavioural model on every clock. The stimulus includes directed overlaps and a long randomized mix of lookups and register traffic.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int NUM_WIN   = 5;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int TGT_W     = 4;
  localparam int GRAN_W    = 16;
  localparam int REG_AW    = 8;
  localparam int TGT_LSB   = 4;
  localparam int PAGE_W    = ADDR_W - GRAN_W;
  localparam int WIN_IDX_W = $clog2(NUM_WIN);
  localparam int SLOT_W    = REG_AW - 4;

  typedef struct packed {
    logic              en;
    logic [TGT_W-1:0]  tgt;
    logic [PAGE_W-1:0] mask;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] remap;
  } win_cfg_t;
endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
  import addr_win_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_en,
  input  logic                        reg_we,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output win_cfg_t [NUM_WIN-1:0]      cfg
);
  logic [SLOT_W-1:0] slot;
  logic [1:0]        fld;
  logic              mapped;

  assign slot   = reg_addr[REG_AW-1:4];
  assign fld    = reg_addr[3:2];
  assign mapped = (reg_addr[1:0] == 2'b00) && (slot < SLOT_W'(NUM_WIN));

  logic [DATA_W-1:0] ctrl_q  [NUM_WIN];
  logic [DATA_W-1:0] size_q  [NUM_WIN];
  logic [DATA_W-1:0] base_q  [NUM_WIN];
  logic [DATA_W-1:0] remap_q [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel, ctrl_we, size_we, base_we, remap_we;

    always_comb begin
      sel      = reg_en && reg_we && mapped && (slot == SLOT_W'(w));
      ctrl_we  = sel && (fld == 2'd0);
      size_we  = sel && (fld == 2'd1);
      base_we  = sel && (fld == 2'd2);
      remap_we = sel && (fld == 2'd3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[w]  <= '0;
        size_q[w]  <= '0;
        base_q[w]  <= '0;
        remap_q[w] <= '0;
      end else begin
        if (ctrl_we)  ctrl_q[w]  <= reg_wdata;
        if (size_we)  size_q[w]  <= reg_wdata;
        if (base_we)  base_q[w]  <= reg_wdata;
        if (remap_we) remap_q[w] <= reg_wdata;
      end
    end

    assign cfg[w].en    = ctrl_q[w][0];
    assign cfg[w].tgt   = ctrl_q[w][TGT_LSB +: TGT_W];
    assign cfg[w].mask  = size_q[w][PAGE_W-1:0];
    assign cfg[w].base  = base_q[w][PAGE_W-1:0];
    assign cfg[w].remap = remap_q[w][PAGE_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (mapped && (slot == SLOT_W'(w))) begin
        case (fld)
          2'd0:    reg_rdata = ctrl_q[w];
          2'd1:    reg_rdata = size_q[w];
          2'd2:    reg_rdata = base_q[w];
          default: reg_rdata = remap_q[w];
        endcase
      end
    end
  end

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && !mapped) |=> $stable(cfg)); // R3
endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
  import addr_win_pkg::*;
(
  input  win_cfg_t [NUM_WIN-1:0]             cfg,
  input  logic [PAGE_W-1:0]                  page,
  output logic [NUM_WIN-1:0]                 hit,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]     xlat_page
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [PAGE_W-1:0] keep;
    assign keep         = ~cfg[w].mask;
    assign hit[w]       = cfg[w].en && ((page & keep) == (cfg[w].base & keep));
    assign xlat_page[w] = (page & cfg[w].mask) | (cfg[w].remap & keep);
  end
endmodule

// File: rtl/addr_win_resolve.sv
module addr_win_resolve
  import addr_win_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               dec_valid,
  input  logic [ADDR_W-1:0]                  dec_addr,
  input  logic [NUM_WIN-1:0]                 hit,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]     xlat_page,
  input  win_cfg_t [NUM_WIN-1:0]             cfg,
  output logic                               out_valid,
  output logic                               out_hit,
  output logic                               out_miss,
  output logic [WIN_IDX_W-1:0]               out_win,
  output logic [TGT_W-1:0]                   out_tgt,
  output logic [ADDR_W-1:0]                  out_addr
);
  logic [NUM_WIN-1:0]   grant;
  logic [WIN_IDX_W-1:0] sel_idx;
  logic [TGT_W-1:0]     sel_tgt;
  logic [PAGE_W-1:0]    sel_page;
  logic                 any_hit;

  always_comb begin
    grant    = '0;
    sel_idx  = '0;
    sel_tgt  = '1;
    sel_page = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        grant    = '0;
        grant[w] = 1'b1;
        sel_idx  = WIN_IDX_W'(w);
        sel_tgt  = cfg[w].tgt;
        sel_page = xlat_page[w];
      end
    end
    any_hit = |hit;
  end

  logic                 valid_d, hit_d, miss_d;
  logic [WIN_IDX_W-1:0] win_d;
  logic [TGT_W-1:0]     tgt_d;
  logic [ADDR_W-1:0]    addr_d;

  always_comb begin
    valid_d = dec_valid;
    hit_d   = dec_valid && any_hit;
    miss_d  = dec_valid && !any_hit;
    win_d   = any_hit ? sel_idx : '0;
    tgt_d   = any_hit ? sel_tgt : '1;
    addr_d  = any_hit ? {sel_page, dec_addr[GRAN_W-1:0]} : dec_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b0;
      out_win   <= '0;
      out_tgt   <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= valid_d;
      out_hit   <= hit_d;
      out_miss  <= miss_d;
      if (dec_valid) begin
        out_win  <= win_d;
        out_tgt  <= tgt_d;
        out_addr <= addr_d;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hit && out_miss)); // R7
  AST_MISS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> (out_tgt == '1)); // R7
  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && any_hit |=> (out_addr[GRAN_W-1:0] == $past(dec_addr[GRAN_W-1:0]))); // R9
  AST_LATENCY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> out_valid); // R10
  AST_LATENCY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> !out_valid && !out_hit && !out_miss); // R10
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import addr_win_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 dec_valid,
  input  logic [ADDR_W-1:0]    dec_addr,
  output logic                 out_valid,
  output logic                 out_hit,
  output logic                 out_miss,
  output logic [WIN_IDX_W-1:0] out_win,
  output logic [TGT_W-1:0]     out_tgt,
  output logic [ADDR_W-1:0]    out_addr
);
  win_cfg_t [NUM_WIN-1:0]           cfg;
  logic [NUM_WIN-1:0]               hit;
  logic [NUM_WIN-1:0][PAGE_W-1:0]   xlat_page;

  addr_win_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg       (cfg)
  );

  addr_win_match u_match (
    .cfg       (cfg),
    .page      (dec_addr[ADDR_W-1:GRAN_W]),
    .hit       (hit),
    .xlat_page (xlat_page)
  );

  addr_win_resolve u_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_addr  (dec_addr),
    .hit       (hit),
    .xlat_page (xlat_page),
    .cfg       (cfg),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_miss  (out_miss),
    .out_win   (out_win),
    .out_tgt   (out_tgt),
    .out_addr  (out_addr)
  );
endmodule

// File: tb/addr_win_decoder_tb.sv
`timescale 1ns/1ps
module addr_win_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dec_valid = 1'b0;
  logic [31:0] dec_addr = '0;
  logic        out_valid, out_hit, out_miss;
  logic [2:0]  out_win;
  logic [3:0]  out_tgt;
  logic [31:0] out_addr;

  always #2.5 clk = ~clk;

  addr_win_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dec_valid(dec_valid), .dec_addr(dec_addr), .out_valid(out_valid),
    .out_hit(out_hit), .out_miss(out_miss), .out_win(out_win),
    .out_tgt(out_tgt), .out_addr(out_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit chk_on = 1'b0;

  // Behavioural reference model
  logic [31:0] m_ctrl[5], m_size[5], m_base[5], m_remap[5];
  logic        e_valid, e_hit, e_miss;
  logic [2:0]  e_win;
  logic [3:0]  e_tgt;
  logic [31:0] e_addr;

  function automatic logic [31:0] model_read(logic [7:0] a);
    if (a[1:0] != 2'b00 || a >= 8'h50) return 32'h0;
    case (a[3:2])
      2'd0: return m_ctrl[a[7:4]];
      2'd1: return m_size[a[7:4]];
      2'd2: return m_base[a[7:4]];
      default: return m_remap[a[7:4]];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < 5; w++) begin
        m_ctrl[w] = 0; m_size[w] = 0; m_base[w] = 0; m_remap[w] = 0;
      end
      e_valid = 0; e_hit = 0; e_miss = 0; e_win = 0; e_tgt = 0; e_addr = 0;
    end else begin
      int hw;
      hw = -1;
      for (int w = 0; w < 5; w++) begin
        logic [15:0] k;
        k = ~m_size[w][15:0];
        if (hw < 0 && m_ctrl[w][0] && ((dec_addr[31:16] & k) == (m_base[w][15:0] & k)))
          hw = w;
      end
      e_valid = dec_valid;
      e_hit   = dec_valid && (hw >= 0);
      e_miss  = dec_valid && (hw < 0);
      if (dec_valid) begin
        if (hw >= 0) begin
          e_win  = 3'(hw);
          e_tgt  = m_ctrl[hw][7:4];
          e_addr = {(dec_addr[31:16] & m_size[hw][15:0]) | (m_remap[hw][15:0] & ~m_size[hw][15:0]),
                    dec_addr[15:0]};
        end else begin
          e_win = 0; e_tgt = 4'hF; e_addr = dec_addr;
        end
      end
      if (reg_en && reg_we && reg_addr[1:0] == 2'b00 && reg_addr < 8'h50) begin
        case (reg_addr[3:2])
          2'd0: m_ctrl[reg_addr[7:4]]  = reg_wdata;
          2'd1: m_size[reg_addr[7:4]]  = reg_wdata;
          2'd2: m_base[reg_addr[7:4]]  = reg_wdata;
          default: m_remap[reg_addr[7:4]] = reg_wdata;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual 0x%08h expected 0x%08h", tag, $time, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      chk(out_valid == e_valid, "R10 valid", 32'(out_valid), 32'(e_valid));
      chk(out_hit == e_hit, "R5 hit", 32'(out_hit), 32'(e_hit));
      chk(out_miss == e_miss, "R7 miss", 32'(out_miss), 32'(e_miss));
      chk(out_win == e_win, "R6 window", 32'(out_win), 32'(e_win));
      chk(out_tgt == e_tgt, "R8 target", 32'(out_tgt), 32'(e_tgt));
      chk(out_addr == e_addr, "R9 address", out_addr, e_addr);
      if (reg_en && !reg_we) begin
        if (reg_addr[1:0] != 2'b00 || reg_addr >= 8'h50)
          chk(reg_rdata == 32'h0, "R3 unmapped read", reg_rdata, 32'h0);
        else
          chk(reg_rdata == model_read(reg_addr), "R1 read-back", reg_rdata, model_read(reg_addr));
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a);
    @(posedge clk); #1;
    reg_en = 1; reg_we = 0; reg_addr = a;
    @(posedge clk); #1;
    reg_en = 0;
  endtask

  task automatic look(logic [31:0] a);
    @(posedge clk); #1;
    dec_valid = 1; dec_addr = a;
    @(posedge clk); #1;
    dec_valid = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state observed at the ports
    chk(out_valid == 0 && out_hit == 0 && out_miss == 0, "R2 flags", 32'(out_hit), 0);
    chk(out_addr == 0 && out_tgt == 0 && out_win == 0, "R2 outputs", out_addr, 0);
    reg_en = 1; reg_addr = 8'h00; #1;
    chk(reg_rdata == 0, "R2 ctrl cleared", reg_rdata, 0);
    reg_en = 0;
    rst_n = 1;
    @(posedge clk); #1;
    chk_on = 1;

    // Window setup
    wr(8'h00, 32'h0000_0001); wr(8'h04, 32'h0000_3FFF); wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    wr(8'h10, 32'h0000_0021); wr(8'h14, 32'h0000_00FF); wr(8'h18, 32'h0000_E800); wr(8'h1C, 32'h0000_E800);
    wr(8'h20, 32'hABCD_0031); wr(8'h24, 32'h0000_000F); wr(8'h28, 32'h0000_4000); wr(8'h2C, 32'h0000_9000);
    wr(8'h30, 32'h0000_0051); wr(8'h34, 32'h0);         wr(8'h38, 32'h0000_0010); wr(8'h3C, 32'h0000_7000);
    wr(8'h40, 32'h0000_0070); wr(8'h44, 32'h0000_FFFF); wr(8'h48, 32'h0);         wr(8'h4C, 32'h0);
    // R1: full read-back of all 20 words
    for (int a = 0; a < 8'h50; a += 4) rd(8'(a));
    // R3: unmapped and misaligned writes are ignored
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF); wr(8'hF0, 32'h1234_5678); wr(8'h06, 32'h0);
    rd(8'h50); rd(8'h01); rd(8'hF0); rd(8'h00); rd(8'h04);

    look(32'h1234_5678);                  // R8 window 0, DRAM code
    look(32'hE812_3456);                  // R8 window 1, code 2
    look(32'h400A_BCDE);                  // R9 remapped to 0x900ABCDE
    @(negedge clk);
    chk(out_addr == 32'h900A_BCDE, "R9 remap", out_addr, 32'h900A_BCDE);
    look(32'h0010_1234);                  // R6 overlap: window 0 beats 3
    @(negedge clk);
    chk(out_win == 3'd0, "R6 lowest wins", 32'(out_win), 0);
    look(32'h8000_0000);                  // R4: disabled window 4 covers all
    @(negedge clk);
    chk(out_miss == 1 && out_tgt == 4'hF, "R4 disabled no hit", 32'(out_tgt), 32'hF);

    wr(8'h00, 32'h0);                     // disable window 0
    look(32'h0010_1234);
    @(negedge clk);
    chk(out_win == 3'd3 && out_addr == 32'h7000_1234, "R6 next window", out_addr, 32'h7000_1234);
    wr(8'h40, 32'h0000_0071);
    look(32'h8000_0000);
    @(negedge clk);
    chk(out_hit == 1 && out_tgt == 4'h7, "R4 enabled hit", 32'(out_tgt), 32'h7);

    // R10: back-to-back lookups with a write in the same cycle
    @(posedge clk); #1;
    dec_valid = 1; dec_addr = 32'h8000_0010;
    reg_en = 1; reg_we = 1; reg_addr = 8'h40; reg_wdata = 32'h0;
    @(posedge clk); #1;
    reg_en = 0; reg_we = 0; dec_addr = 32'h8000_0020;
    @(posedge clk); #1;
    dec_valid = 0;
    repeat (3) @(posedge clk);

    // Randomized mix, checked against the model every cycle
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      dec_valid = ($urandom % 4) != 0;
      if ($urandom % 2) dec_addr = {m_base[$urandom % 5][15:0] ^ 16'($urandom % 4), 16'($urandom)};
      else dec_addr = $urandom;
      reg_en = 1;
      reg_we = ($urandom % 6) == 0;
      reg_addr = 8'($urandom % 8'h58);
      if ($urandom % 3 == 0) reg_addr[1:0] = 2'b00;
      reg_wdata = $urandom;
      if (reg_we && reg_addr[3:2] == 2'd1) reg_wdata = (32'h1 << ($urandom % 17)) - 1;
    end
    @(posedge clk); #1;
    reg_en = 0; reg_we = 0; dec_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    finish_run();
  end
endmodule